// File: doc/BRIEF.md
# Bit-oriented message receiver

This block recovers bit-oriented messages from a serial line. Each message word is a 0xFF flag byte followed by a data byte whose first and last bits are zero. The receiver hunts bit by bit for a 0xFF byte and confirms it with a second 0xFF on the byte boundary. It then samples byte-aligned words. Qualifying data bytes go into an internal receive queue, with the first bit received in the least significant position.

Sampling stops in two ways. A 0x7E word, or too long a run of 0xFF words, ends the message and raises a one-cycle message-end pulse. Two idle conditions also stop sampling: a long run of ones, or a long window that never holds eight consecutive ones. Each idle condition stores a status entry that closes the frame and raises a one-cycle idle pulse. A tag bit on every queue entry tells data from status. A sticky flag records any write that found the queue full; such a write is dropped.

Top module: `bom_rx`

## Requirements
- R1: Sampling starts only after a 0xFF byte is followed, on the next byte boundary, by a second 0xFF byte. If the second byte is anything else, hunting starts again from scratch, and bytes that follow are not stored.
- R2: The first 0xFF is found at any bit offset; bits received before it are ignored.
- R3: While sampling, a byte whose first and last received bits are both 0 is stored with tag 0 (`rd_is_status`=0), with the first received bit as bit 0 of `rd_data`.
- R4: While sampling, a byte whose first or last bit is 1 is not stored, and a 0xFF byte is never stored.
- R5: While sampling, a 0x7E byte stores nothing, pulses `msg_end_irq` for one cycle and stops sampling. Sampling resumes only after two aligned 0xFF bytes again.
- R6: The fifth consecutive 0xFF byte, counting the two sync bytes, stops sampling and pulses `msg_end_irq`; nothing is stored.
- R7: While sampling, the 32nd consecutive one (counted from the start of sampling) stops sampling. It stores the status entry 0x00 with tag 1 and pulses `idle_irq`.
- R8: While sampling, 32 bits without a run of eight consecutive ones (counted from the start of sampling or from the last such run) stop sampling. They store the status entry 0x01 with tag 1 and pulse `idle_irq`.
- R9: The queue returns entries in the order they were written. `rd_en` while `fifo_empty` is 0 yields the oldest entry with `rd_valid` high on the next cycle. `rd_en` while empty is ignored.
- R10: A write into a full queue is dropped without disturbing stored entries, and sets `overflow`, which stays 1 until reset.
- R11: After reset the queue is empty, `overflow`, `rd_valid`, `msg_end_irq` and `idle_irq` are 0, and the receiver is hunting.
- R12: When an idle condition falls on the same bit as a byte boundary, the idle rule wins and that byte is not judged or stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Qualifies `bit_in` for this cycle |
| bit_in | input | 1 | Serial received bit |
| rd_en | input | 1 | Pop the oldest queue entry |
| fifo_empty | output | 1 | Queue holds no entry |
| rd_valid | output | 1 | `rd_data`/`rd_is_status` carry a popped entry |
| rd_data | output | 8 | Popped byte |
| rd_is_status | output | 1 | Popped entry is a status entry (1) or data (0) |
| overflow | output | 1 | Sticky: a write found the queue full |
| msg_end_irq | output | 1 | One-cycle message-end pulse |
| idle_irq | output | 1 | One-cycle idle pulse |

## Verification
The bench builds the block with a queue depth of 4 and the default thresholds: 32 ones for idle, a 32-bit window, a run mark of 8 and a limit of four 0xFF bytes. A depth of 4 lets a single short frame of five data bytes fill the queue and reach the overflow drop. The default thresholds bring a crafted stream within reach that trips the 32-ones rule ahead of the 0xFF-run rule. A zero stream after sync puts the window idle on the same bit as a byte boundary.

// File: rtl/bom_rx_pkg.sv
package bom_rx_pkg;
  typedef enum logic [1:0] {
    ST_HUNT   = 2'd0,
    ST_SYNC2  = 2'd1,
    ST_SAMPLE = 2'd2
  } bom_state_e;

  localparam logic [7:0] FLAG_BYTE   = 8'hFF;
  localparam logic [7:0] END_BYTE    = 8'h7E;
  localparam logic [7:0] STAT_ONES   = 8'h00;
  localparam logic [7:0] STAT_NOSYNC = 8'h01;
endpackage

// File: rtl/bom_rx_idle_mon.sv
module bom_rx_idle_mon #(
  parameter int IDLE_ONES = 32,
  parameter int WIN_BITS  = 32,
  parameter int RUN_MARK  = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic bit_en,
  input  logic bit_in,
  output logic ones_hit,
  output logic win_hit
);
  localparam int RW = $clog2(IDLE_ONES + 1);
  localparam int WW = $clog2(WIN_BITS + 1);

  logic [RW-1:0] run_q, run_nx;
  logic [WW-1:0] win_q, win_nx;

  always_comb begin
    if (bit_in) begin
      run_nx = (run_q == RW'(IDLE_ONES)) ? run_q : run_q + RW'(1);
    end else begin
      run_nx = '0;
    end
    if (bit_in && run_nx == RW'(RUN_MARK)) begin
      win_nx = '0;
    end else begin
      win_nx = (win_q == WW'(WIN_BITS)) ? win_q : win_q + WW'(1);
    end
    ones_hit = active && bit_en && (run_nx == RW'(IDLE_ONES));
    win_hit  = active && bit_en && (win_nx == WW'(WIN_BITS));
  end

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      run_q <= '0;
      win_q <= '0;
    end else if (bit_en) begin
      run_q <= run_nx;
      win_q <= win_nx;
    end
  end

  AST_IDLE_LEAVES: assert property (@(posedge clk) disable iff (rst)
    (ones_hit || win_hit) |=> !active); // R7

  AST_ONES_NEED_ONE: assert property (@(posedge clk) disable iff (rst)
    ones_hit |-> bit_in); // R7
endmodule

// File: rtl/bom_rx_framer.sv
module bom_rx_framer
  import bom_rx_pkg::*;
#(
  parameter int END_FF_RUN = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bit_en,
  input  logic       bit_in,
  input  logic       ones_hit,
  input  logic       win_hit,
  output logic       sampling,
  output logic       wr_valid,
  output logic       wr_tag,
  output logic [7:0] wr_data,
  output logic       msg_end_irq,
  output logic       idle_irq
);
  localparam int FW = $clog2(END_FF_RUN + 1);

  bom_state_e    state;
  logic [7:0]    sh;
  logic [7:0]    nb;
  logic [2:0]    bc;
  logic [FW-1:0] ffcnt;

  assign nb       = {bit_in, sh[7:1]};
  assign sampling = (state == ST_SAMPLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_HUNT;
      sh          <= '0;
      bc          <= '0;
      ffcnt       <= '0;
      wr_valid    <= 1'b0;
      wr_tag      <= 1'b0;
      wr_data     <= '0;
      msg_end_irq <= 1'b0;
      idle_irq    <= 1'b0;
    end else begin
      wr_valid    <= 1'b0;
      msg_end_irq <= 1'b0;
      idle_irq    <= 1'b0;
      if (bit_en) begin
        case (state)
          ST_HUNT: begin
            sh <= nb;
            bc <= '0;
            if (nb == FLAG_BYTE) state <= ST_SYNC2;
          end
          ST_SYNC2: begin
            sh <= nb;
            bc <= bc + 3'd1;
            if (bc == 3'd7) begin
              if (nb == FLAG_BYTE) begin
                state <= ST_SAMPLE;
                ffcnt <= FW'(2);
              end else begin
                state <= ST_HUNT;
                sh    <= '0;
              end
            end
          end
          ST_SAMPLE: begin
            sh <= nb;
            bc <= bc + 3'd1;
            if (ones_hit || win_hit) begin
              idle_irq <= 1'b1;
              wr_valid <= 1'b1;
              wr_tag   <= 1'b1;
              wr_data  <= ones_hit ? STAT_ONES : STAT_NOSYNC;
              state    <= ST_HUNT;
              sh       <= '0;
              bc       <= '0;
            end else if (bc == 3'd7) begin
              if (nb == END_BYTE) begin
                msg_end_irq <= 1'b1;
                state       <= ST_HUNT;
                sh          <= '0;
              end else if (nb == FLAG_BYTE) begin
                if (ffcnt >= FW'(END_FF_RUN)) begin
                  msg_end_irq <= 1'b1;
                  state       <= ST_HUNT;
                  sh          <= '0;
                end else begin
                  ffcnt <= ffcnt + FW'(1);
                end
              end else begin
                ffcnt <= '0;
                if (!nb[0] && !nb[7]) begin
                  wr_valid <= 1'b1;
                  wr_tag   <= 1'b0;
                  wr_data  <= nb;
                end
              end
            end
          end
          default: begin
            state <= ST_HUNT;
            sh    <= '0;
          end
        endcase
      end
    end
  end

  AST_END_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    msg_end_irq |-> !wr_valid); // R5

  AST_STOPS_SAMPLING: assert property (@(posedge clk) disable iff (rst)
    (msg_end_irq || idle_irq) |-> state != ST_SAMPLE); // R5

  AST_IDLE_STATUS: assert property (@(posedge clk) disable iff (rst)
    idle_irq |-> (wr_valid && wr_tag)); // R7

  AST_DATA_FORM: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !wr_tag) |-> (!wr_data[0] && !wr_data[7] && $past(state) == ST_SAMPLE)); // R3

  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (rst)
    !(msg_end_irq && idle_irq)); // R12
endmodule

// File: rtl/bom_rx_fifo.sv
module bom_rx_fifo #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_word,
  input  logic             rd_en,
  output logic             empty,
  output logic             rd_valid,
  output logic [WIDTH-1:0] rd_word,
  output logic             overflow
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    count;
  logic             full, do_wr, do_rd;

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
  assign do_wr = wr_en && !full;
  assign do_rd = rd_en && !empty;

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr] <= wr_word;
  end

  always_ff @(posedge clk) begin
    if (do_rd) rd_word <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      count    <= '0;
      rd_valid <= 1'b0;
      overflow <= 1'b0;
    end else begin
      rd_valid <= do_rd;
      if (do_wr) wr_ptr <= wr_ptr + AW'(1);
      if (do_rd) rd_ptr <= rd_ptr + AW'(1);
      case ({do_wr, do_rd})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
      if (wr_en && full) overflow <= 1'b1;
    end
  end

  AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
    (wr_en && full && !rd_en) |=> count == $past(count)); // R10

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow); // R10

  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (rst)
    (rd_en && empty) |=> !rd_valid); // R9

  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH)); // R9
endmodule

// File: rtl/bom_rx.sv
module bom_rx
  import bom_rx_pkg::*;
#(
  parameter int FIFO_DEPTH = 64,
  parameter int IDLE_ONES  = 32,
  parameter int WIN_BITS   = 32,
  parameter int RUN_MARK   = 8,
  parameter int END_FF_RUN = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bit_en,
  input  logic       bit_in,
  input  logic       rd_en,
  output logic       fifo_empty,
  output logic       rd_valid,
  output logic [7:0] rd_data,
  output logic       rd_is_status,
  output logic       overflow,
  output logic       msg_end_irq,
  output logic       idle_irq
);
  localparam int QW = 9;

  logic          sampling, ones_hit, win_hit;
  logic          wr_valid, wr_tag;
  logic [7:0]    wr_data;
  logic [QW-1:0] rd_word;

  bom_rx_idle_mon #(
    .IDLE_ONES(IDLE_ONES),
    .WIN_BITS (WIN_BITS),
    .RUN_MARK (RUN_MARK)
  ) u_idle (
    .clk     (clk),
    .rst     (rst),
    .active  (sampling),
    .bit_en  (bit_en),
    .bit_in  (bit_in),
    .ones_hit(ones_hit),
    .win_hit (win_hit)
  );

  bom_rx_framer #(
    .END_FF_RUN(END_FF_RUN)
  ) u_framer (
    .clk        (clk),
    .rst        (rst),
    .bit_en     (bit_en),
    .bit_in     (bit_in),
    .ones_hit   (ones_hit),
    .win_hit    (win_hit),
    .sampling   (sampling),
    .wr_valid   (wr_valid),
    .wr_tag     (wr_tag),
    .wr_data    (wr_data),
    .msg_end_irq(msg_end_irq),
    .idle_irq   (idle_irq)
  );

  bom_rx_fifo #(
    .DEPTH(FIFO_DEPTH),
    .WIDTH(QW)
  ) u_fifo (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_valid),
    .wr_word ({wr_tag, wr_data}),
    .rd_en   (rd_en),
    .empty   (fifo_empty),
    .rd_valid(rd_valid),
    .rd_word (rd_word),
    .overflow(overflow)
  );

  assign rd_data      = rd_word[7:0];
  assign rd_is_status = rd_word[8];
endmodule

// File: tb/bom_rx_tb.sv
`timescale 1ns/1ps
module bom_rx_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bit_en = 1'b0;
  logic       bit_in = 1'b0;
  logic       rd_en = 1'b0;
  logic       fifo_empty, rd_valid, rd_is_status, overflow, msg_end_irq, idle_irq;
  logic [7:0] rd_data;

  int checks = 0;
  int failures = 0;
  int n_end = 0;
  int n_idle = 0;
  bit reader_on = 1'b1;
  bit poke = 1'b0;
  logic [8:0] exp_q[$];
  string      req_q[$];

  always #5 clk = ~clk;

  bom_rx #(.FIFO_DEPTH(4)) u_dut (
    .clk(clk), .rst(rst), .bit_en(bit_en), .bit_in(bit_in), .rd_en(rd_en),
    .fifo_empty(fifo_empty), .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_is_status(rd_is_status), .overflow(overflow),
    .msg_end_irq(msg_end_irq), .idle_irq(idle_irq)
  );

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic expect_item(input logic tag, input logic [7:0] d, input string req);
    exp_q.push_back({tag, d});
    req_q.push_back(req);
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    bit_en = 1'b1;
    bit_in = b;
    @(negedge clk);
    bit_en = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) send_bit(v[i]);
  endtask

  task automatic settle();
    repeat (20) @(negedge clk);
  endtask

  // monitor: pops the scoreboard, counts pulses, drives rd_en
  always @(negedge clk) begin
    if (!rst) begin
      if (msg_end_irq) n_end++;
      if (idle_irq) n_idle++;
      if (rd_valid) begin
        if (exp_q.size() == 0) begin
          chk("R9 unexpected entry", {23'd0, rd_is_status, rd_data}, 32'h1ff);
        end else begin
          automatic logic [8:0] e = exp_q.pop_front();
          automatic string r = req_q.pop_front();
          chk(r, {23'd0, rd_is_status, rd_data}, {23'd0, e});
        end
      end
      if (poke) begin
        rd_en = 1'b1;
        poke  = 1'b0;
      end else begin
        rd_en = reader_on && !fifo_empty;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog got=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk("R11 empty", fifo_empty, 1);
    chk("R11 overflow", overflow, 0);
    chk("R11 rd_valid", rd_valid, 0);
    chk("R11 pulses", {msg_end_irq, idle_irq}, 0);

    // R2 offset hunt, R3 store, R5 end on 0x7E
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    send_byte(8'hFF); send_byte(8'hFF);
    expect_item(1'b0, 8'h18, "R2 R3 data after offset sync");
    send_byte(8'h18); send_byte(8'hFF);
    expect_item(1'b0, 8'h42, "R3 second data byte");
    send_byte(8'h42); send_byte(8'hFF); send_byte(8'h7E);
    send_byte(8'h00);
    settle();
    chk("R5 message end count", n_end, 1);

    // R1 failed second sync byte, then proper sync; R5 resume
    send_byte(8'hFF); send_byte(8'h00); send_byte(8'h24);
    send_byte(8'hFF); send_byte(8'hFF);
    expect_item(1'b0, 8'h5A, "R1 R5 data after resync");
    send_byte(8'h5A); send_byte(8'hFF); send_byte(8'h7E);
    send_byte(8'h00);
    settle();
    chk("R1 message end count", n_end, 2);

    // R4 discard rules
    send_byte(8'hFF); send_byte(8'hFF);
    send_byte(8'h43); send_byte(8'hFF);
    send_byte(8'hC2); send_byte(8'hFF);
    expect_item(1'b0, 8'h3C, "R4 only valid byte kept");
    send_byte(8'h3C); send_byte(8'hFF); send_byte(8'h7E);
    send_byte(8'h00);
    settle();
    chk("R4 message end count", n_end, 3);
    chk("R4 queue drained", exp_q.size(), 0);

    // R6 fifth consecutive 0xFF
    send_byte(8'hFF); send_byte(8'hFF);
    send_byte(8'hFF); send_byte(8'hFF);
    settle();
    chk("R6 no end at fourth 0xFF", n_end, 3);
    send_byte(8'hFF);
    settle();
    chk("R6 end at fifth 0xFF", n_end, 4);
    chk("R6 nothing stored", fifo_empty, 1);
    send_byte(8'h00);

    // R8 window idle, R12 idle wins on boundary
    send_byte(8'hFF); send_byte(8'hFF);
    expect_item(1'b0, 8'h00, "R8 zero byte 1");
    expect_item(1'b0, 8'h00, "R8 zero byte 2");
    expect_item(1'b0, 8'h00, "R8 zero byte 3");
    expect_item(1'b1, 8'h01, "R8 R12 window status");
    send_byte(8'h00); send_byte(8'h00); send_byte(8'h00); send_byte(8'h00);
    settle();
    chk("R8 idle count", n_idle, 1);
    chk("R12 no message end", n_end, 4);
    send_byte(8'h00);

    // R7 32 ones while sampling
    send_byte(8'hFF); send_byte(8'hFF);
    send_byte(8'hFE); send_byte(8'hFF); send_byte(8'hFF); send_byte(8'hFF);
    expect_item(1'b1, 8'h00, "R7 ones status");
    send_byte(8'h01);
    settle();
    chk("R7 idle count", n_idle, 2);
    chk("R7 no message end", n_end, 4);
    chk("R7 queue drained", exp_q.size(), 0);

    // R10 overflow with reading paused
    reader_on = 1'b0;
    settle();
    send_byte(8'hFF); send_byte(8'hFF);
    send_byte(8'h12); send_byte(8'hFF);
    send_byte(8'h24); send_byte(8'hFF);
    send_byte(8'h36); send_byte(8'hFF);
    send_byte(8'h48); send_byte(8'hFF);
    settle();
    chk("R10 no overflow when just full", overflow, 0);
    send_byte(8'h5A); send_byte(8'hFF); send_byte(8'h7E);
    settle();
    chk("R10 overflow set", overflow, 1);
    chk("R10 not empty", fifo_empty, 0);
    chk("R10 message end count", n_end, 5);
    expect_item(1'b0, 8'h12, "R9 R10 order 1");
    expect_item(1'b0, 8'h24, "R9 R10 order 2");
    expect_item(1'b0, 8'h36, "R9 R10 order 3");
    expect_item(1'b0, 8'h48, "R9 R10 order 4");
    reader_on = 1'b1;
    settle();
    chk("R10 drained", exp_q.size(), 0);
    chk("R10 overflow sticky", overflow, 1);
    chk("R9 empty after drain", fifo_empty, 1);

    // R9 read while empty is ignored
    reader_on = 1'b0;
    @(posedge clk); #1 poke = 1'b1;
    @(negedge clk);
    @(negedge clk); #1;
    chk("R9 empty read gives no entry", rd_valid, 0);
    chk("R9 still empty", fifo_empty, 1);
    settle();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule